// File: doc/BRIEF.md
# PLL Divider Search Engine

This block works out the divider settings for an integer-mode PLL that runs from a fixed 24 MHz reference. A request supplies the wanted output frequency in kHz. The engine first picks the two post dividers, which place the VCO inside its legal band. It then tries each reference divider in turn. For each one it rounds the feedback divider to the nearest usable integer and measures the remaining VCO error. The candidate with the lowest error is kept. When the search ends, the engine reports the reference, feedback and both post dividers, or it raises an error.

All division runs on one shared serial restoring divider. One division takes a fixed number of cycles: one cycle per bit of the divider width. A full search therefore takes a bounded time of a few thousand cycles. A controller pulses `start` with a frequency, waits for `done`, and then reads the result. The engine does not write PLL registers.

The controller is a state machine with these states and transitions:
- IDLE launches the first post-divider division on `start`. A zero request finishes at once with an error.
- PD1_WT waits for that division and goes to PD2_GO.
- PD2_GO goes to PD2_WT when post divider 1 exceeds the limit, and to VCO_CHK otherwise.
- PD2_WT goes to PD1R_GO, and PD1R_GO goes to PD1R_WT. Together they recompute post divider 1, then go to VCO_CHK.
- VCO_CHK either finishes with an error or enters SWEEP.
- SWEEP launches the division of the reference by the current reference divider and goes to REF_WT. It finishes instead when the divider limit is reached or an exact match is held.
- REF_WT goes to FB_GO. FB_GO launches the VCO division and goes to FB_WT.
- FB_WT goes to EVAL. EVAL scores the candidate and returns to SWEEP.
- Every finish returns to IDLE.

Top module: `pll_div_search`

## Requirements
- R1: A request of 0 kHz finishes with no search. In the cycle after `start` is sampled, `done` is 1, `err` is 1 and `busy` stays 0.
- R2: Post divider 1 starts as ceil(800000 / f). If it exceeds 7, post divider 2 becomes ceil(pd1 / 7) and post divider 1 becomes ceil(old pd1 / pd2). Otherwise post divider 2 is 1. Both are reported on success.
- R3: The request fails with `err` = 1 when post divider 2 exceeds 7, or when f·pd1·pd2 lies outside 800000..3200000 kHz.
- R4: For reference divider r in 1..62, the divided reference is fr = 24000 / r (truncated). The feedback value is q = VCO / fr with remainder d. A candidate is skipped when q ≥ 3200 or q ≤ 16. When d > fr/2 (truncated) and q+1 < 3200, q is incremented and the error becomes fr − d. Otherwise the error is d.
- R5: The best error starts at the VCO value. A candidate replaces the best only when its error is strictly smaller, so the smallest divider wins a tie. The sweep stops after the first zero-error candidate.
- R6: The search fails when no candidate was accepted or when the best error exceeds the parameter ERR_LIM_KHZ (default 4000).
- R7: Whenever `err` is 1, all four divider outputs are 0.
- R8: `busy` rises in the cycle after an accepted `start`. It stays high until the cycle in which the one-cycle `done` pulse appears, and it is low in that cycle.
- R9: `start` and `freq_khz` are ignored while `busy` is high. The result reflects the frequency sampled with the accepted `start`.
- R10: `done`, `err` and the divider outputs hold their values between searches.
- R11: After reset, `busy`, `done`, `err` and all divider outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse, accepted only while idle |
| freq_khz | input | FREQ_W | Requested output frequency in kHz |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Request could not be met |
| ref_div | output | RD_W | Chosen reference divider |
| fb_div | output | FB_W | Chosen feedback divider |
| post_div1 | output | PD_W | First post divider |
| post_div2 | output | PD_W | Second post divider |

## Verification
The bench builds two copies of the engine with FREQ_W = 24, so requests far above the VCO band can be made. One copy keeps the default error limit of 4000 kHz. With that limit, a 24 MHz reference and 62 trial dividers almost always leave a residual error well below the limit. The second copy therefore uses ERR_LIM_KHZ = 0, which brings the error-threshold path within reach: any request without an exact match must fail there. Each request also exercises the two-stage post-divider path, the rounding guard near the feedback ceiling, and the early stop on exact matches.

// File: rtl/pll_search_pkg.sv
package pll_search_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PD1_WT,
        ST_PD2_GO,
        ST_PD2_WT,
        ST_PD1R_GO,
        ST_PD1R_WT,
        ST_VCO_CHK,
        ST_SWEEP,
        ST_REF_WT,
        ST_FB_GO,
        ST_FB_WT,
        ST_EVAL
    } srch_state_t;

endpackage

// File: rtl/pll_serial_div.sv
// Restoring divider: one quotient bit per cycle, W cycles per operation.
module pll_serial_div #(
    parameter int W = 30
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output logic [W-1:0] quo,
    output logic [W-1:0] rem,
    output logic         valid
);
    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  acc_q, quo_q, den_q;
    logic [CW-1:0] cnt_q;
    logic          run_q, valid_q;
    logic [W:0]    shifted, trial;
    logic          ge;

    always_comb begin
        shifted = {acc_q, quo_q[W-1]};
        trial   = shifted - {1'b0, den_q};
        ge      = shifted >= {1'b0, den_q};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q   <= '0;
            quo_q   <= '0;
            den_q   <= '0;
            cnt_q   <= '0;
            run_q   <= 1'b0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (go) begin
                acc_q <= '0;
                quo_q <= num;
                den_q <= den;
                cnt_q <= CW'(W);
                run_q <= 1'b1;
            end else if (run_q) begin
                acc_q <= ge ? trial[W-1:0] : shifted[W-1:0];
                quo_q <= {quo_q[W-2:0], ge};
                cnt_q <= cnt_q - CW'(1);
                if (cnt_q == CW'(1)) begin
                    run_q   <= 1'b0;
                    valid_q <= 1'b1;
                end
            end
        end
    end

    assign quo   = quo_q;
    assign rem   = acc_q;
    assign valid = valid_q;
endmodule

// File: rtl/pll_cand_eval.sv
// Scores one feedback candidate against the best error held so far.
module pll_cand_eval #(
    parameter int W        = 30,
    parameter int FB_W     = 12,
    parameter int FB_FLOOR = 16,
    parameter int FB_LIM   = 3200
) (
    input  logic [W-1:0]    fb_raw,
    input  logic [W-1:0]    fb_rem,
    input  logic [W-1:0]    fref,
    input  logic [W-1:0]    best,
    output logic            take,
    output logic [FB_W-1:0] fb_out,
    output logic [W-1:0]    err_out
);
    logic in_band, round_up;

    always_comb begin
        in_band  = (fb_raw > W'(FB_FLOOR)) && (fb_raw < W'(FB_LIM));
        round_up = ((fb_raw + W'(1)) < W'(FB_LIM)) && (fb_rem > (fref >> 1));
        fb_out   = round_up ? fb_raw[FB_W-1:0] + FB_W'(1) : fb_raw[FB_W-1:0];
        err_out  = round_up ? fref - fb_rem : fb_rem;
        take     = in_band && (err_out < best);
    end
endmodule

// File: rtl/pll_div_search.sv
module pll_div_search
    import pll_search_pkg::*;
#(
    parameter int FREQ_W      = 24,
    parameter int REF_KHZ     = 24000,
    parameter int VCO_LO_KHZ  = 800000,
    parameter int VCO_HI_KHZ  = 3200000,
    parameter int PD_MAX      = 7,
    parameter int REFDIV_LIM  = 63,
    parameter int FB_FLOOR    = 16,
    parameter int FB_LIM      = 3200,
    parameter int ERR_LIM_KHZ = 4000,
    localparam int PD_W  = $clog2(PD_MAX + 1),
    localparam int RD_W  = $clog2(REFDIV_LIM + 1),
    localparam int FB_W  = $clog2(FB_LIM + 1),
    localparam int DIV_W = FREQ_W + 2 * PD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [FREQ_W-1:0] freq_khz,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [RD_W-1:0]   ref_div,
    output logic [FB_W-1:0]   fb_div,
    output logic [PD_W-1:0]   post_div1,
    output logic [PD_W-1:0]   post_div2
);
    srch_state_t st_q, st_d;

    logic [FREQ_W-1:0] freq_q;
    logic [DIV_W-1:0]  pd1_q, pd2_q, vco_q, best_q, fref_q;
    logic [RD_W-1:0]   rd_q, best_rd_q;
    logic [FB_W-1:0]   best_fb_q;
    logic              found_q;

    logic              div_go, div_valid;
    logic [DIV_W-1:0]  div_num, div_den, div_quo, div_rem, div_ceil;
    logic [DIV_W-1:0]  vco_calc, cand_err;
    logic [FB_W-1:0]   cand_fb;
    logic              cand_take, fin, fin_err;

    pll_serial_div #(.W(DIV_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (div_go),
        .num   (div_num),
        .den   (div_den),
        .quo   (div_quo),
        .rem   (div_rem),
        .valid (div_valid)
    );

    pll_cand_eval #(
        .W(DIV_W), .FB_W(FB_W), .FB_FLOOR(FB_FLOOR), .FB_LIM(FB_LIM)
    ) u_eval (
        .fb_raw  (div_quo),
        .fb_rem  (div_rem),
        .fref    (fref_q),
        .best    (best_q),
        .take    (cand_take),
        .fb_out  (cand_fb),
        .err_out (cand_err)
    );

    always_comb begin
        div_ceil = div_quo + {{(DIV_W-1){1'b0}}, (div_rem != '0)};
        vco_calc = DIV_W'(freq_q) * DIV_W'(pd1_q[PD_W-1:0]) * DIV_W'(pd2_q[PD_W-1:0]);
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Transitions and divider launches
    always_comb begin
        st_d    = st_q;
        div_go  = 1'b0;
        div_num = '0;
        div_den = '0;
        fin     = 1'b0;
        fin_err = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (start) begin
                    if (freq_khz == '0) begin
                        fin     = 1'b1;
                        fin_err = 1'b1;
                    end else begin
                        div_go  = 1'b1;
                        div_num = DIV_W'(VCO_LO_KHZ);
                        div_den = DIV_W'(freq_khz);
                        st_d    = ST_PD1_WT;
                    end
                end
            end
            ST_PD1_WT:  if (div_valid) st_d = ST_PD2_GO;
            ST_PD2_GO: begin
                if (pd1_q > DIV_W'(PD_MAX)) begin
                    div_go  = 1'b1;
                    div_num = pd1_q;
                    div_den = DIV_W'(PD_MAX);
                    st_d    = ST_PD2_WT;
                end else begin
                    st_d = ST_VCO_CHK;
                end
            end
            ST_PD2_WT:  if (div_valid) st_d = ST_PD1R_GO;
            ST_PD1R_GO: begin
                div_go  = 1'b1;
                div_num = pd1_q;
                div_den = pd2_q;
                st_d    = ST_PD1R_WT;
            end
            ST_PD1R_WT: if (div_valid) st_d = ST_VCO_CHK;
            ST_VCO_CHK: begin
                if (pd2_q > DIV_W'(PD_MAX) || vco_calc < DIV_W'(VCO_LO_KHZ) ||
                    vco_calc > DIV_W'(VCO_HI_KHZ)) begin
                    fin     = 1'b1;
                    fin_err = 1'b1;
                    st_d    = ST_IDLE;
                end else begin
                    st_d = ST_SWEEP;
                end
            end
            ST_SWEEP: begin
                if (rd_q < RD_W'(REFDIV_LIM) && best_q != '0) begin
                    div_go  = 1'b1;
                    div_num = DIV_W'(REF_KHZ);
                    div_den = DIV_W'(rd_q);
                    st_d    = ST_REF_WT;
                end else begin
                    fin     = 1'b1;
                    fin_err = !found_q || (best_q > DIV_W'(ERR_LIM_KHZ));
                    st_d    = ST_IDLE;
                end
            end
            ST_REF_WT:  if (div_valid) st_d = ST_FB_GO;
            ST_FB_GO: begin
                div_go  = 1'b1;
                div_num = vco_q;
                div_den = fref_q;
                st_d    = ST_FB_WT;
            end
            ST_FB_WT:   if (div_valid) st_d = ST_EVAL;
            ST_EVAL:    st_d = ST_SWEEP;
            default:    st_d = ST_IDLE;
        endcase
    end

    // Search datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            freq_q    <= '0;
            pd1_q     <= '0;
            pd2_q     <= '0;
            vco_q     <= '0;
            best_q    <= '0;
            fref_q    <= '0;
            rd_q      <= '0;
            best_rd_q <= '0;
            best_fb_q <= '0;
            found_q   <= 1'b0;
        end else begin
            unique case (st_q)
                ST_IDLE: if (start) begin
                    freq_q  <= freq_khz;
                    pd2_q   <= DIV_W'(1);
                    found_q <= 1'b0;
                end
                ST_PD1_WT:  if (div_valid) pd1_q <= div_ceil;
                ST_PD2_WT:  if (div_valid) pd2_q <= div_ceil;
                ST_PD1R_WT: if (div_valid) pd1_q <= div_ceil;
                ST_VCO_CHK: begin
                    vco_q  <= vco_calc;
                    best_q <= vco_calc;
                    rd_q   <= RD_W'(1);
                end
                ST_REF_WT:  if (div_valid) fref_q <= div_quo;
                ST_EVAL: begin
                    if (cand_take) begin
                        best_q    <= cand_err;
                        best_rd_q <= rd_q;
                        best_fb_q <= cand_fb;
                        found_q   <= 1'b1;
                    end
                    rd_q <= rd_q + RD_W'(1);
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done      <= 1'b0;
            err       <= 1'b0;
            ref_div   <= '0;
            fb_div    <= '0;
            post_div1 <= '0;
            post_div2 <= '0;
        end else begin
            done <= fin;
            if (fin) begin
                err       <= fin_err;
                ref_div   <= fin_err ? '0 : best_rd_q;
                fb_div    <= fin_err ? '0 : best_fb_q;
                post_div1 <= fin_err ? '0 : pd1_q[PD_W-1:0];
                post_div2 <= fin_err ? '0 : pd2_q[PD_W-1:0];
            end
        end
    end

    assign busy = (st_q != ST_IDLE);
endmodule

// File: rtl/pll_div_search_chk.sv
module pll_div_search_chk #(
    parameter int FREQ_W     = 24,
    parameter int RD_W       = 6,
    parameter int FB_W       = 12,
    parameter int PD_W       = 3,
    parameter int FB_FLOOR   = 16,
    parameter int FB_LIM     = 3200,
    parameter int REFDIV_LIM = 63
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [FREQ_W-1:0] freq_khz,
    input logic              busy,
    input logic              done,
    input logic              err,
    input logic [RD_W-1:0]   ref_div,
    input logic [FB_W-1:0]   fb_div,
    input logic [PD_W-1:0]   post_div1,
    input logic [PD_W-1:0]   post_div2
);
    // R1
    zero_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && freq_khz == '0) |=> (done && err));

    // R8
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R8
    busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R7
    err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (ref_div == '0 && fb_div == '0 && post_div1 == '0 && post_div2 == '0));

    // R4
    fb_band_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err) |-> (fb_div > FB_W'(FB_FLOOR) && fb_div < FB_W'(FB_LIM)
                            && ref_div != '0 && ref_div < RD_W'(REFDIV_LIM)));

    // R2
    pd_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err) |-> (post_div1 != '0 && post_div2 != '0));

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable({err, ref_div, fb_div, post_div1, post_div2}));
endmodule

bind pll_div_search pll_div_search_chk #(
    .FREQ_W(FREQ_W), .RD_W(RD_W), .FB_W(FB_W), .PD_W(PD_W),
    .FB_FLOOR(FB_FLOOR), .FB_LIM(FB_LIM), .REFDIV_LIM(REFDIV_LIM)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .freq_khz(freq_khz),
    .busy(busy), .done(done), .err(err), .ref_div(ref_div),
    .fb_div(fb_div), .post_div1(post_div1), .post_div2(post_div2)
);

// File: tb/pll_div_search_tb.sv
module pll_div_search_tb;
    localparam int FW  = 24;
    localparam int TMO = 20000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [FW-1:0] freq = '0;

    logic       busy_a, done_a, err_a, busy_b, done_b, err_b;
    logic [5:0] rd_a, rd_b;
    logic [11:0] fb_a, fb_b;
    logic [2:0] p1_a, p2_a, p1_b, p2_b;

    int vectors = 0;
    int miscompares = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    pll_div_search #(.FREQ_W(FW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .freq_khz(freq),
        .busy(busy_a), .done(done_a), .err(err_a), .ref_div(rd_a),
        .fb_div(fb_a), .post_div1(p1_a), .post_div2(p2_a)
    );

    pll_div_search #(.FREQ_W(FW), .ERR_LIM_KHZ(0)) u_dut_strict (
        .clk(clk), .rst_n(rst_n), .start(start), .freq_khz(freq),
        .busy(busy_b), .done(done_b), .err(err_b), .ref_div(rd_b),
        .fb_div(fb_b), .post_div1(p1_b), .post_div2(p2_b)
    );

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Behavioural model of the requirements (R2..R6)
    function automatic void model(input longint f, input longint lim, output bit e,
                                  output longint rd, output longint fb,
                                  output longint p1, output longint p2);
        longint a, b, vco, best, fr, q, d, br, bq;
        bit found;
        e = 1'b0; rd = 0; fb = 0; p1 = 0; p2 = 0;
        br = 0; bq = 0; found = 1'b0;
        if (f == 0) begin e = 1'b1; return; end
        a = (800000 + f - 1) / f;
        b = 1;
        if (a > 7) begin
            b = (a + 6) / 7;
            a = (a + b - 1) / b;
        end
        if (b > 7) begin e = 1'b1; return; end
        vco = f * a * b;
        if (vco < 800000 || vco > 3200000) begin e = 1'b1; return; end
        best = vco;
        for (longint r = 1; r < 63 && best != 0; r++) begin
            fr = 24000 / r;
            q  = vco / fr;
            if (q >= 3200 || q <= 16) continue;
            d = vco - q * fr;
            if (q + 1 < 3200 && d > fr / 2) begin
                q = q + 1;
                d = fr - d;
            end
            if (d >= best) continue;
            best = d; br = r; bq = q; found = 1'b1;
        end
        if (!found || best > lim) begin e = 1'b1; return; end
        rd = br; fb = bq; p1 = a; p2 = b;
    endfunction

    task automatic run_req(input longint f, input bit disturb, input string req);
        bit e_a, e_b;
        longint rda, fba, p1a, p2a, rdb, fbb, p1b, p2b;
        int cyc;
        bit seen_a, seen_b;
        model(f, 4000, e_a, rda, fba, p1a, p2a);
        model(f, 0, e_b, rdb, fbb, p1b, p2b);
        @(negedge clk);
        freq  = FW'(f);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (disturb) freq = FW'(20000);
        cyc = 0; seen_a = 1'b0; seen_b = 1'b0;
        while (!(seen_a && seen_b) && cyc < TMO) begin
            if (!seen_a) begin
                if (done_a) begin
                    seen_a = 1'b1;
                    if (f == 0) chk("R1", "done latency", cyc, 0);
                    chk("R8", "busy at done", busy_a, 0);
                    chk(req, "err", err_a, e_a);
                    chk(req, "ref_div", rd_a, rda);
                    chk(req, "fb_div", fb_a, fba);
                    chk(req, "post_div1", p1_a, p1a);
                    chk(req, "post_div2", p2_a, p2a);
                end else begin
                    chk("R8", "busy while searching", busy_a, 1);
                end
            end
            if (!seen_b && done_b) begin
                seen_b = 1'b1;
                chk("R6", "strict err", err_b, e_b);
                chk("R6", "strict ref_div", rd_b, rdb);
                chk("R6", "strict fb_div", fb_b, fbb);
                chk("R6", "strict post_div1", p1_b, p1b);
                chk("R6", "strict post_div2", p2_b, p2b);
            end
            if (disturb && cyc == 40) start = 1'b1;
            if (disturb && cyc == 41) start = 1'b0;
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        if (!(seen_a && seen_b)) chk(req, "done timeout", 0, 1);
    endtask

    task automatic hold_check();
        logic [23:0] snap;
        snap = {err_a, rd_a, fb_a, p1_a, p2_a};
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            freq = FW'(i * 777);
            chk("R10", "done idle", done_a, 0);
        end
        chk("R10", "outputs held", {err_a, rd_a, fb_a, p1_a, p2_a}, snap);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            miscompares++;
            vectors++;
            $display("FAIL watchdog: actual %0d cycles expected below 190000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R11", "busy in reset", busy_a, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11", "busy", busy_a, 0);
        chk("R11", "done", done_a, 0);
        chk("R11", "err", err_a, 0);
        chk("R11", "results", {rd_a, fb_a, p1_a, p2_a}, 0);

        run_req(0, 1'b0, "R1");
        run_req(1, 1'b0, "R7");
        run_req(16000, 1'b0, "R3");
        run_req(3200001, 1'b0, "R3");
        run_req(5000000, 1'b0, "R3");
        run_req(20000, 1'b0, "R2");
        run_req(100000, 1'b0, "R2");
        run_req(33333, 1'b0, "R2");
        run_req(3199900, 1'b0, "R4");
        run_req(3200000, 1'b0, "R4");
        run_req(1600000, 1'b0, "R5");
        run_req(148500, 1'b0, "R5");
        hold_check();
        run_req(600000, 1'b0, "R5");
        run_req(800000, 1'b0, "R4");
        run_req(148500, 1'b1, "R9");
        run_req(2500000, 1'b0, "R4");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule